// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block gives software a way to measure what a processor core is doing. It holds a free-running cycle counter and two event counters, each as wide as the data word. Each event counter chooses one strobe from a wide event bus that the core drives. While its chosen strobe is high on a clock edge, the event counter adds one. A single control word carries several things: the master enable, two self-clearing reset commands, a divide-by-64 option for the cycle counter, per-counter interrupt enables, sticky overflow flags and the two event selectors.

Software reaches the control word and the three counters through a simple register port. Writes take effect on the clock edge. Reads are combinational from the addressed register. A counter that wraps from all ones to zero sets its overflow flag. A single level-sensitive interrupt line reports any flag whose enable bit is set.

Top module: `perf_mon_unit`

## Requirements
- R1: While control bit 0 (enable) is clear, none of the three counters changes except through a register write or a reset command.
- R2: A control write with bit 1 set clears both event counters to zero on that edge.
- R3: A control write with bit 2 set clears the cycle counter and its 6-bit prescaler to zero on that edge.
- R4: With control bit 3 set, the cycle counter advances once per 64 enabled clocks. The first step comes on the 64th enabled edge after the prescaler was cleared. With bit 3 clear, the counter advances on every enabled edge.
- R5: Event counter 0 adds one on each enabled edge where event strobe number control[19:12] is high. Event counter 1 does the same for strobe number control[27:20].
- R6: The register addresses are 0 for control, 1 for the cycle counter, 2 for event counter 0 and 3 for event counter 1. In the control word, bits 1, 2, 7, 11 and 31:28 always read 0. Bits 0, 3, 6:4 and 27:12 read back the value last written.
- R7: A counter that steps from all ones to zero sets its overflow flag. The flags are bit 8 for event counter 0, bit 9 for event counter 1 and bit 10 for the cycle counter.
- R8: An overflow flag stays set until a control write has a 1 in that bit position. A 0 written there leaves the flag unchanged.
- R9: The interrupt output is high exactly while some overflow flag is set together with its enable. The enables are bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the cycle counter.
- R10: A write to a counter address loads the written value. The load wins over an increment on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register address (0 control, 1 cycle, 2 event 0, 3 event 1) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register, combinational |
| evt_bus | input | 256 | Event strobes from the core, one bit per event number |
| irq | output | 1 | Interrupt, high while an enabled overflow flag is set |

## Verification
A write lands on the first rising edge after the strobe, and a read reflects register state with no delay. The bench therefore drives each write and each event strobe on a falling edge, and samples one time step after a falling edge. That way every count equals the exact number of rising edges the bench let pass. An event held high for n falling-edge intervals must add exactly n. A wrap is set up two edges ahead, so its flag and the interrupt must appear after exactly the second edge. In divide mode the cycle counter must still read 0 after 63 edges and read 1 after the 64th.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
package pmu_pkg;
    localparam int SEL_W   = 8;
    localparam int NUM_EVT = 1 << SEL_W;
    localparam int NCNT    = 3;

    // Counter slots; the slot order matches the flag and enable bit order.
    localparam int SLOT_EV0 = 0;
    localparam int SLOT_EV1 = 1;
    localparam int SLOT_CYC = 2;

    // Control word bit positions
    localparam int B_EN    = 0;
    localparam int B_CLREV = 1;
    localparam int B_CLRCY = 2;
    localparam int B_DIV   = 3;
    localparam int B_IE    = 4;
    localparam int B_OVF   = 8;
    localparam int B_SEL0  = 12;
    localparam int B_SEL1  = B_SEL0 + SEL_W;

    // Register addresses
    localparam logic [1:0] A_CTL = 2'd0;
    localparam logic [1:0] A_CYC = 2'd1;
    localparam logic [1:0] A_EV0 = 2'd2;
    localparam logic [1:0] A_EV1 = 2'd3;

    typedef struct packed {
        logic             en;
        logic             div;
        logic [NCNT-1:0]  ie;
        logic [NCNT-1:0]  ovf;
        logic [SEL_W-1:0] sel0;
        logic [SEL_W-1:0] sel1;
    } ctl_t;
endpackage

// File: rtl/pmu_prescale.sv
`timescale 1ns/1ps
module pmu_prescale #(
    parameter int PRE_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic tick_o
);
    logic [PRE_W-1:0] div_d, div_q;

    always_comb begin
        div_d  = div_q;
        tick_o = run_i && (&div_q);
        if (clr_i)      div_d = '0;
        else if (run_i) div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/pmu_counter.sv
`timescale 1ns/1ps
module pmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] count_o,
    output logic         wrap_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        wrap_o = 1'b0;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i) begin
            cnt_d  = cnt_q + 1'b1;
            wrap_o = &cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/perf_mon_unit.sv
`timescale 1ns/1ps
module perf_mon_unit
    import pmu_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [CNT_W-1:0]   reg_wdata,
    output logic [CNT_W-1:0]   reg_rdata,
    input  logic [NUM_EVT-1:0] evt_bus,
    output logic               irq
);
    ctl_t ctl_d, ctl_q;

    logic                        ctl_wr;
    logic                        clr_ev, clr_cy;
    logic                        pre_tick;
    logic [NCNT-1:0]             inc, load, clr, wrap;
    logic [NCNT-1:0][CNT_W-1:0]  cnt;

    assign ctl_wr = reg_wr && (reg_addr == A_CTL);
    assign clr_ev = ctl_wr && reg_wdata[B_CLREV];
    assign clr_cy = ctl_wr && reg_wdata[B_CLRCY];

    pmu_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_cy),
        .run_i  (ctl_q.en),
        .tick_o (pre_tick)
    );

    // Per-slot increment, load and clear sources
    always_comb begin
        inc[SLOT_EV0]  = ctl_q.en && evt_bus[ctl_q.sel0];
        inc[SLOT_EV1]  = ctl_q.en && evt_bus[ctl_q.sel1];
        inc[SLOT_CYC]  = ctl_q.en && (!ctl_q.div || pre_tick);
        load[SLOT_EV0] = reg_wr && (reg_addr == A_EV0);
        load[SLOT_EV1] = reg_wr && (reg_addr == A_EV1);
        load[SLOT_CYC] = reg_wr && (reg_addr == A_CYC);
        clr[SLOT_EV0]  = clr_ev;
        clr[SLOT_EV1]  = clr_ev;
        clr[SLOT_CYC]  = clr_cy;
    end

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        pmu_counter #(.W(CNT_W)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (load[i]),
            .load_val_i (reg_wdata),
            .clr_i      (clr[i]),
            .inc_i      (inc[i]),
            .count_o    (cnt[i]),
            .wrap_o     (wrap[i])
        );
    end

    // Control next state: fields load on a control write, flags are
    // write-one-to-clear, and a new wrap on the same edge wins over the clear.
    always_comb begin
        ctl_d = ctl_q;
        if (ctl_wr) begin
            ctl_d.en   = reg_wdata[B_EN];
            ctl_d.div  = reg_wdata[B_DIV];
            ctl_d.ie   = reg_wdata[B_IE +: NCNT];
            ctl_d.sel0 = reg_wdata[B_SEL0 +: SEL_W];
            ctl_d.sel1 = reg_wdata[B_SEL1 +: SEL_W];
            ctl_d.ovf  = ctl_q.ovf & ~reg_wdata[B_OVF +: NCNT];
        end
        ctl_d.ovf = ctl_d.ovf | wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTL: begin
                reg_rdata[B_EN]                = ctl_q.en;
                reg_rdata[B_DIV]               = ctl_q.div;
                reg_rdata[B_IE +: NCNT]        = ctl_q.ie;
                reg_rdata[B_OVF +: NCNT]       = ctl_q.ovf;
                reg_rdata[B_SEL0 +: SEL_W]     = ctl_q.sel0;
                reg_rdata[B_SEL1 +: SEL_W]     = ctl_q.sel1;
            end
            A_CYC:   reg_rdata = cnt[SLOT_CYC];
            A_EV0:   reg_rdata = cnt[SLOT_EV0];
            default: reg_rdata = cnt[SLOT_EV1];
        endcase
    end

    assign irq = |(ctl_q.ovf & ctl_q.ie);
endmodule

// File: rtl/pmu_checker.sv
`timescale 1ns/1ps
module pmu_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [CNT_W-1:0] reg_wdata,
    input logic [CNT_W-1:0] reg_rdata,
    input logic             irq,
    input logic             en,
    input logic [2:0]       ie,
    input logic [2:0]       ovf,
    input logic [CNT_W-1:0] cyc,
    input logic [CNT_W-1:0] ev0
);
    logic ctl_wr;
    assign ctl_wr = reg_wr && (reg_addr == 2'd0);

    a_r1_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !reg_wr) |=> ($stable(cyc) && $stable(ev0)));

    a_r2_event_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && reg_wdata[1]) |=> (ev0 == '0));

    a_r3_cycle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && reg_wdata[2]) |=> (cyc == '0));

    a_r6_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> (reg_rdata[2:1] == 2'b00 && !reg_rdata[7] &&
                                !reg_rdata[11] && reg_rdata[31:28] == 4'd0));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf[2] && !ctl_wr) |=> ovf[2]);

    a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ie == 3'b000) |-> !irq);

    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1) |=> (cyc == $past(reg_wdata)));
endmodule

bind perf_mon_unit pmu_checker #(.CNT_W(CNT_W)) u_pmu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .en        (ctl_q.en),
    .ie        (ctl_q.ie),
    .ovf       (ctl_q.ovf),
    .cyc       (cnt[2]),
    .ev0       (cnt[0])
);

// File: tb/test_perf_mon_unit.sv
`timescale 1ns/1ps
module test_perf_mon_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [255:0] evt_bus = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    perf_mon_unit i_perf_mon_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_bus(evt_bus), .irq(irq)
    );

    // sel0, sel1, strobe line, edges, expected ev0, expected ev1
    localparam logic [47:0] VEC [0:5] = '{
        {8'd3,   8'd7,   8'd3,   8'd5,  8'd5,  8'd0},
        {8'd3,   8'd7,   8'd7,   8'd9,  8'd0,  8'd9},
        {8'd10,  8'd10,  8'd10,  8'd4,  8'd4,  8'd4},
        {8'd255, 8'd0,   8'd255, 8'd12, 8'd12, 8'd0},
        {8'd0,   8'd128, 8'd0,   8'd6,  8'd6,  8'd0},
        {8'd0,   8'd128, 8'd128, 8'd3,  8'd0,  8'd3}
    };

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic chk_reg(input logic [1:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            fails++;
            $display("FAIL %s: addr %0d actual %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        #1;
        checks++;
        if (irq !== exp) begin
            fails++;
            $display("FAIL %s: irq actual %b expected %b", tag, irq, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk_reg(2'd0, 32'h0, "reset ctl R6");
        chk_reg(2'd1, 32'h0, "reset cycle R3");
        chk_reg(2'd2, 32'h0, "reset ev0 R5");
        chk_reg(2'd3, 32'h0, "reset ev1 R5");
        chk_irq(1'b0, "reset irq R9");

        // R5: event selection table
        for (int k = 0; k < 6; k++) begin
            logic [7:0] s0, s1, ln, n, e0, e1;
            {s0, s1, ln, n, e0, e1} = VEC[k];
            wr(2'd0, 32'h0);
            wr(2'd0, 32'h7 | (32'(s0) << 12) | (32'(s1) << 20));
            evt_bus[ln] = 1'b1;
            repeat (int'(n)) @(negedge clk);
            evt_bus = '0;
            chk_reg(2'd2, 32'(e0), "R5 event counter 0");
            chk_reg(2'd3, 32'(e1), "R5 event counter 1");
        end

        // R1: disabled, events present, nothing counts
        wr(2'd0, 32'h0);
        wr(2'd0, 32'h6 | (32'd4 << 12));
        evt_bus[4] = 1'b1;
        repeat (8) @(negedge clk);
        evt_bus = '0;
        chk_reg(2'd2, 32'h0, "R1 ev0 frozen");
        chk_reg(2'd1, 32'h0, "R1 cycle frozen");

        // R4: plain cycle counting
        wr(2'd0, 32'h5);
        repeat (10) @(negedge clk);
        chk_reg(2'd1, 32'd10, "R4 cycle every clock");

        // R4 and R3: divide-by-64 from a cleared prescaler
        wr(2'd0, 32'h0);
        wr(2'd0, 32'hD);
        repeat (63) @(negedge clk);
        chk_reg(2'd1, 32'd0, "R4 div64 before 64th edge");
        @(negedge clk);
        chk_reg(2'd1, 32'd1, "R4 div64 at 64th edge");
        repeat (64) @(negedge clk);
        chk_reg(2'd1, 32'd2, "R4 div64 at 128th edge");

        // R7 cycle wrap, R9 irq, R10 load
        wr(2'd0, 32'h0);
        wr(2'd1, 32'hFFFF_FFFE);
        chk_reg(2'd1, 32'hFFFF_FFFE, "R10 cycle load");
        wr(2'd0, 32'h41);
        @(negedge clk);
        chk_reg(2'd0, 32'h41, "R7 no flag before wrap");
        @(negedge clk);
        chk_reg(2'd1, 32'h0, "R7 cycle wrapped");
        chk_reg(2'd0, 32'h441, "R7 cycle flag set");
        chk_irq(1'b1, "R9 irq with enable");
        repeat (5) @(negedge clk);
        chk_reg(2'd0, 32'h441, "R8 flag sticky");
        chk_reg(2'd1, 32'd5, "R7 counting after wrap");
        wr(2'd0, 32'h1);
        chk_reg(2'd0, 32'h401, "R8 zero write keeps flag");
        chk_irq(1'b0, "R9 irq masked");
        wr(2'd0, 32'h401);
        chk_reg(2'd0, 32'h001, "R8 write one clears flag");

        // R7 event counter 1 wrap
        wr(2'd0, 32'h0);
        wr(2'd3, 32'hFFFF_FFFF);
        wr(2'd0, 32'h21 | (32'd5 << 20));
        evt_bus[5] = 1'b1;
        @(negedge clk);
        evt_bus = '0;
        chk_reg(2'd3, 32'h0, "R7 ev1 wrapped");
        chk_reg(2'd0, 32'h0050_0221, "R7 ev1 flag");
        chk_irq(1'b1, "R9 ev1 irq");
        wr(2'd0, 32'h200);
        chk_reg(2'd0, 32'h0, "R8 ev1 flag cleared");
        chk_irq(1'b0, "R9 irq dropped");

        // R10 load beats increment; R2 clears events
        wr(2'd0, 32'h3 | (32'd9 << 12));
        evt_bus[9] = 1'b1;
        repeat (3) @(negedge clk);
        chk_reg(2'd2, 32'd3, "R5 ev0 counting");
        wr(2'd2, 32'd100);
        evt_bus = '0;
        chk_reg(2'd2, 32'd100, "R10 load over increment");
        wr(2'd0, 32'h3 | (32'd9 << 12));
        chk_reg(2'd2, 32'd0, "R2 event clear");

        // R6 readback of all-ones write
        wr(2'd0, 32'hFFFF_FFFF);
        chk_reg(2'd0, 32'h0FFF_F079, "R6 control readback");
        wr(2'd0, 32'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule